// File: doc/BRIEF.md
# Processor Presence Bitmap with Hotplug Event

This block tracks which processors of a system are currently present. It keeps one presence bit per processor id and packs the bits eight to a byte, so firmware reads the map one byte at a time through a small window. Two event inputs tell the block that a processor was added or removed. Each input carries the id of the processor. Each accepted event updates the matching bit, sets a sticky event status flag and drives the interrupt request again.

At reset the map is loaded from a vector that lists the processors that already exist. This load raises no event. Firmware clears the status flag with an acknowledge pulse and gates the interrupt with an enable input. The window has a write strobe and a write data bus, but writes never change the map. An id outside the supported range is treated as illegal and dropped.

Top module: `hp_cpu_presence`

## Requirements
- R1: While reset is asserted the bitmap takes the value of `init_present`, where bit N is processor N. After reset `evt_sts`, `irq` and `rd_data` are 0. The initial load raises no event.
- R2: A read strobe with offset K updates `rd_data` one clock later. Bit J of that byte is the presence bit of processor 8*K+J, and the value is the map as it stood before any event taken in the same cycle. Without a read strobe, `rd_data` holds its value.
- R3: A legal plug event for id N sets presence bit N from the next clock on.
- R4: A legal unplug event for id N clears presence bit N from the next clock on.
- R5: When a plug and an unplug for the same id arrive in one cycle, the unplug wins and the bit ends up cleared. Events for different ids in the same cycle both take effect.
- R6: Any legal plug or unplug event sets `evt_sts` on the next clock. The flag stays set until a cycle with `evt_ack` high and no legal event clears it. An event coinciding with an acknowledge leaves the flag set.
- R7: `irq` is high exactly when `evt_sts` is set and `irq_en` is high. It follows `irq_en` in the same cycle.
- R8: An event whose id is 256 or more is illegal. It changes no presence bit and does not set `evt_sts`.
- R9: Writes to the window (`wr_en` with any `rd_addr` and `wr_data`) change no presence bit and no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_present | input | 256 | Processors present at start, loaded during reset |
| plug_valid | input | 1 | Processor-added event strobe |
| plug_id | input | 9 | Id of the added processor |
| unplug_valid | input | 1 | Processor-removed event strobe |
| unplug_id | input | 9 | Id of the removed processor |
| rd_en | input | 1 | Window read strobe |
| rd_addr | input | 5 | Window byte offset |
| wr_en | input | 1 | Window write strobe (ignored) |
| wr_data | input | 8 | Window write data (ignored) |
| evt_ack | input | 1 | Clears the event status flag |
| irq_en | input | 1 | Interrupt enable |
| rd_data | output | 8 | Byte read from the window |
| evt_sts | output | 1 | Sticky hotplug event flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench plugs every one of the 256 ids in turn and then unplugs every id in turn, starting from a reset map with every third processor present. After each event it reads back the affected byte and checks the status flag. This sweep tells apart errors in the byte index from errors in the bit index, and it separates set from clear. Coinciding plug and unplug events for the same id and for different ids check the priority. Out-of-range ids and a write sweep over every offset are each followed by a full dump of all 32 bytes. This shows that nothing else in the map moved. Acknowledge, enable and event timing are tried in combination to separate the sticky flag from the gated interrupt.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int unsigned HP_BYTE_W = 8;

    typedef struct packed {
        logic sts;
    } hp_evt_state_t;
endpackage

// File: rtl/hp_id_filter.sv
module hp_id_filter #(
    parameter int NPROC = 256,
    parameter int ID_W  = 9,
    localparam int IDX_W = $clog2(NPROC)
) (
    input  logic             valid,
    input  logic [ID_W-1:0]  id,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    // An id is legal only when it names an existing bit of the map
    always_comb begin
        hit = valid && (int'(id) < NPROC);
        idx = id[IDX_W-1:0];
    end
endmodule

// File: rtl/hp_bitmap.sv
module hp_bitmap #(
    parameter int NPROC = 256,
    localparam int IDX_W = $clog2(NPROC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPROC-1:0] init_present,
    input  logic             set_hit,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_hit,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [NPROC-1:0] bits
);
    typedef struct packed {
        logic [NPROC-1:0] bits;
    } map_state_t;

    map_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_hit) st_d.bits[set_idx] = 1'b1;
        // applied last so removal wins on a same-id collision
        if (clr_hit) st_d.bits[clr_idx] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.bits <= init_present;
        else        st_q      <= st_d;
    end

    assign bits = st_q.bits;
endmodule

// File: rtl/hp_event.sv
module hp_event
    import hp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_hit,
    input  logic ack,
    input  logic irq_en,
    output logic sts,
    output logic irq
);
    hp_evt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (any_hit)  st_d.sts = 1'b1;
        else if (ack) st_d.sts = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts = st_q.sts;
    assign irq = st_q.sts & irq_en;
endmodule

// File: rtl/hp_rdport.sv
module hp_rdport
    import hp_pkg::*;
#(
    parameter int NPROC = 256,
    localparam int NBYTES = NPROC / HP_BYTE_W,
    localparam int ADDR_W = $clog2(NBYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [NPROC-1:0]     bits,
    output logic [HP_BYTE_W-1:0] rd_data
);
    typedef struct packed {
        logic [HP_BYTE_W-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [HP_BYTE_W-1:0] bytes [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_slice
        assign bytes[g] = bits[g*HP_BYTE_W +: HP_BYTE_W];
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) st_d.data = bytes[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data;
endmodule

// File: rtl/hp_cpu_presence.sv
module hp_cpu_presence
    import hp_pkg::*;
#(
    parameter int NPROC = 256,
    parameter int ID_W  = 9,
    localparam int NBYTES = NPROC / HP_BYTE_W,
    localparam int ADDR_W = $clog2(NBYTES),
    localparam int IDX_W  = $clog2(NPROC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPROC-1:0]     init_present,
    input  logic                 plug_valid,
    input  logic [ID_W-1:0]      plug_id,
    input  logic                 unplug_valid,
    input  logic [ID_W-1:0]      unplug_id,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic                 wr_en,
    input  logic [HP_BYTE_W-1:0] wr_data,
    input  logic                 evt_ack,
    input  logic                 irq_en,
    output logic [HP_BYTE_W-1:0] rd_data,
    output logic                 evt_sts,
    output logic                 irq
);
    logic             plug_hit, unplug_hit;
    logic [IDX_W-1:0] plug_idx, unplug_idx;
    logic [NPROC-1:0] bitmap;

    // the window is read-only; write inputs are deliberately consumed here
    logic unused_wr;
    assign unused_wr = ^{wr_en, wr_data};

    hp_id_filter #(.NPROC(NPROC), .ID_W(ID_W)) u_plug_f (
        .valid(plug_valid), .id(plug_id), .hit(plug_hit), .idx(plug_idx)
    );

    hp_id_filter #(.NPROC(NPROC), .ID_W(ID_W)) u_unplug_f (
        .valid(unplug_valid), .id(unplug_id), .hit(unplug_hit), .idx(unplug_idx)
    );

    hp_bitmap #(.NPROC(NPROC)) u_map (
        .clk(clk), .rst_n(rst_n), .init_present(init_present),
        .set_hit(plug_hit), .set_idx(plug_idx),
        .clr_hit(unplug_hit), .clr_idx(unplug_idx),
        .bits(bitmap)
    );

    hp_event u_evt (
        .clk(clk), .rst_n(rst_n), .any_hit(plug_hit | unplug_hit),
        .ack(evt_ack), .irq_en(irq_en), .sts(evt_sts), .irq(irq)
    );

    hp_rdport #(.NPROC(NPROC)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .bits(bitmap), .rd_data(rd_data)
    );
endmodule

// File: rtl/hp_presence_chk.sv
module hp_presence_chk #(
    parameter int NPROC = 256,
    parameter int ID_W  = 9,
    localparam int NBYTES = NPROC / 8,
    localparam int ADDR_W = $clog2(NBYTES),
    localparam int IDX_W  = $clog2(NPROC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              plug_valid,
    input logic [ID_W-1:0]   plug_id,
    input logic              unplug_valid,
    input logic [ID_W-1:0]   unplug_id,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic              evt_ack,
    input logic              evt_sts,
    input logic [NPROC-1:0]  bitmap
);
    logic p_ok, u_ok;
    assign p_ok = plug_valid && (int'(plug_id) < NPROC);
    assign u_ok = unplug_valid && (int'(unplug_id) < NPROC);

    AST_PLUG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok && !(u_ok && unplug_id == plug_id)) |=> bitmap[$past(plug_id[IDX_W-1:0])]); // R3

    AST_UNPLUG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        u_ok |=> !bitmap[$past(unplug_id[IDX_W-1:0])]); // R5

    AST_EVT_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (p_ok || u_ok) |=> evt_sts); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ack && !p_ok && !u_ok) |=> !evt_sts); // R6

    AST_MAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!p_ok && !u_ok) |=> $stable(bitmap)); // R8

    AST_READ_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_data == $past(bitmap[{rd_addr, 3'b000} +: 8])); // R2

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R2
endmodule

bind hp_cpu_presence hp_presence_chk #(.NPROC(NPROC), .ID_W(ID_W)) u_chk (.*);

// File: tb/tb_hp_cpu_presence.sv
module tb_hp_cpu_presence;
    localparam int NP = 256;
    localparam int IW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] init_present;
    logic          plug_valid = 0, unplug_valid = 0;
    logic [IW-1:0] plug_id = '0, unplug_id = '0;
    logic          rd_en = 0, wr_en = 0, evt_ack = 0, irq_en = 0;
    logic [4:0]    rd_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic          evt_sts, irq;

    logic [NP-1:0] model;
    int            n_chk = 0, n_fail = 0;
    bit            done = 0;

    always #10 clk = ~clk;   // 50 MHz

    hp_cpu_presence dut (
        .clk(clk), .rst_n(rst_n), .init_present(init_present),
        .plug_valid(plug_valid), .plug_id(plug_id),
        .unplug_valid(unplug_valid), .unplug_id(unplug_id),
        .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_data(wr_data),
        .evt_ack(evt_ack), .irq_en(irq_en),
        .rd_data(rd_data), .evt_sts(evt_sts), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic event_cyc(input logic p, input int pid, input logic u, input int uid);
        plug_valid = p; plug_id = IW'(pid);
        unplug_valid = u; unplug_id = IW'(uid);
        @(negedge clk);
        plug_valid = 0; unplug_valid = 0;
    endtask

    task automatic ack_cyc();
        evt_ack = 1;
        @(negedge clk);
        evt_ack = 0;
    endtask

    task automatic read_byte(input int k, output logic [7:0] v);
        rd_en = 1; rd_addr = 5'(k);
        @(negedge clk);
        v = rd_data;
        rd_en = 0;
    endtask

    task automatic dump_cmp(input string req);
        logic [7:0] v;
        for (int k = 0; k < NP/8; k++) begin
            read_byte(k, v);
            chk(req, int'(v), int'(model[k*8 +: 8]));
        end
    endtask

    initial begin
        logic [7:0] v;
        for (int i = 0; i < NP; i++) init_present[i] = (i % 3 == 0);
        model = init_present;
        repeat (3) @(negedge clk);
        chk("R1 evt_sts", int'(evt_sts), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        rst_n = 1;
        @(negedge clk);
        dump_cmp("R1 init map");
        chk("R1 no event after load", int'(evt_sts), 0);

        // plug sweep
        for (int id = 0; id < NP; id++) begin
            event_cyc(1, id, 0, 0);
            model[id] = 1'b1;
            chk("R6 set on plug", int'(evt_sts), 1);
            read_byte(id / 8, v);
            chk("R3 plug byte", int'(v), int'(model[(id/8)*8 +: 8]));
            ack_cyc();
            chk("R6 ack clears", int'(evt_sts), 0);
        end
        // unplug sweep
        for (int id = 0; id < NP; id++) begin
            event_cyc(0, 0, 1, id);
            model[id] = 1'b0;
            chk("R6 set on unplug", int'(evt_sts), 1);
            read_byte(id / 8, v);
            chk("R4 unplug byte", int'(v), int'(model[(id/8)*8 +: 8]));
            ack_cyc();
        end

        // read mapping and hold
        event_cyc(1, 8*3 + 5, 0, 0); model[29] = 1'b1;
        read_byte(3, v);
        chk("R2 bit position", int'(v), 8'h20);
        rd_addr = 5'd7;
        @(negedge clk);
        chk("R2 hold without strobe", int'(rd_data), 8'h20);
        // read in the same cycle as an event sees the old map
        rd_en = 1; rd_addr = 5'd4; plug_valid = 1; plug_id = 9'd33;
        @(negedge clk);
        rd_en = 0; plug_valid = 0; model[33] = 1'b1;
        chk("R2 read before event", int'(rd_data), 0);
        ack_cyc();

        // collisions
        event_cyc(1, 10, 1, 10); model[10] = 1'b0;
        dump_cmp("R5 same id unplug wins");
        event_cyc(1, 200, 0, 0); model[200] = 1'b1;
        event_cyc(1, 200, 1, 200); model[200] = 1'b0;
        read_byte(25, v);
        chk("R5 same id clears set bit", int'(v), int'(model[200 +: 8]));
        event_cyc(1, 20, 1, 29); model[20] = 1'b1; model[29] = 1'b0;
        dump_cmp("R5 different ids");
        ack_cyc();

        // illegal ids
        event_cyc(1, 256, 0, 0);
        chk("R8 no status plug", int'(evt_sts), 0);
        event_cyc(0, 0, 1, 300);
        event_cyc(1, 511, 1, 257);
        chk("R8 no status", int'(evt_sts), 0);
        dump_cmp("R8 map untouched");

        // writes ignored
        for (int k = 0; k < NP/8; k++) begin
            wr_en = 1; rd_addr = 5'(k); wr_data = 8'(~k);
            @(negedge clk);
        end
        wr_en = 0;
        chk("R9 no status", int'(evt_sts), 0);
        dump_cmp("R9 map untouched");

        // interrupt gating
        irq_en = 0;
        event_cyc(1, 5, 0, 0); model[5] = 1'b1;
        chk("R7 masked", int'(irq), 0);
        irq_en = 1; #1;
        chk("R7 enabled", int'(irq), 1);
        irq_en = 0; #1;
        chk("R7 disabled again", int'(irq), 0);
        irq_en = 1;
        ack_cyc();
        chk("R7 cleared by ack", int'(irq), 0);
        // ack with simultaneous event keeps flag
        evt_ack = 1;
        event_cyc(1, 6, 0, 0); model[6] = 1'b1;
        evt_ack = 0;
        chk("R6 event beats ack", int'(evt_sts), 1);
        chk("R7 follows status", int'(irq), 1);
        dump_cmp("R3 final map");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule